// File: doc/BRIEF.md
# Bus Break Condition Matcher

This block snoops a shared system bus that carries physical addresses and is used by several masters, such as the CPU and a DMA engine. It compares every valid bus cycle against the conditions programmed into a set of independent channels. Each channel holds a compare address, a per-bit ignore mask and a control word. The control word selects the cycle type (instruction fetch, data access, either, or none), the direction and the transfer size. The default build has two channels.

Every cycle that satisfies a channel's conditions sets that channel's sticky match flag, whichever master issued it. The same match raises a one-cycle break request toward the CPU, unless the CPU's block bit is set during that bus cycle. While the block bit is set, matching and flag setting carry on as normal. Software programs the channels and clears the flags with simple register writes.

A cycle is classified as an instruction fetch only when the CPU master issues it with the fetch qualifier set. This includes the cache fill that a fetch triggers. Every other cycle is a data access, and this includes any cycle from the DMA master.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset all match flags and the break request are 0, and every channel's cycle-type select is "none".
- R2: A channel's address condition holds when the bus address equals the compare address in every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored. No address translation is applied.
- R3: The cycle-type select is control bits [1:0]: 0 = none (the channel is disabled and never sets its flag), 1 = instruction fetch only, 2 = data access only, 3 = either.
- R4: A cycle is an instruction fetch only when `bus_master` equals the CPU id (0) and `bus_fetch` is 1. A cycle from the DMA id (1) is a data access even when `bus_fetch` is 1.
- R5: The direction select is control bits [3:2]: 0 or 3 = any, 1 = reads only (`bus_write`=0), 2 = writes only (`bus_write`=1).
- R6: The size select is control bits [5:4]: 0 = byte, 1 = word, 2 = longword, 3 = any. It is compared against `bus_size`, which uses the same codes 0, 1 and 2.
- R7: A match flag stays 1 until a write to that channel's clear register, which is register 3. A match in the same cycle as the clear write wins, and the flag stays 1.
- R8: A matching bus cycle sampled at one clock edge shows as the flag at 1 and `break_req` at 1 right after that edge. `break_req` falls after the next edge unless another match occurs.
- R9: When `cpu_block` is 1 during the matching bus cycle, `break_req` stays 0 but the channel's flag is still set.
- R10: The channels are independent. One cycle can set several flags, and clearing one channel leaves the others unchanged.
- R11: Cycles from any master id, including masters other than the CPU and the DMA engine, are checked and can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | {channel, register}; register 0 = address, 1 = mask, 2 = control, 3 = flag clear |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Physical bus address |
| bus_fetch | input | 1 | Cycle was caused by a CPU instruction fetch |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_master | input | 2 | Id of the issuing master (0 CPU, 1 DMA) |
| cpu_block | input | 1 | CPU block bit; suppresses break requests |
| match_flag | output | 2 | Sticky per-channel match flags |
| break_req | output | 1 | One-cycle break request to the CPU |

## Verification
A wrong compare register or a wrong classification shows up on the cycle right after the offending bus cycle. The channel's flag either fails to rise or rises when it should not. Because the flag is sticky, a false set stays visible at the port until a clear write, so every bus cycle in the bench is followed by an exact flag comparison one edge later. A fault in the block-bit gating or in the pulse logic shows as `break_req` being wrong in that same sampled cycle. A flag that drops with no clear write shows as soon as the bench samples an idle cycle.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_DATA  = 2'd2,
        CYC_ANY   = 2'd3
    } cyc_sel_e;

    typedef enum logic [1:0] {
        DIR_ANY0  = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2,
        DIR_ANY1  = 2'd3
    } dir_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ANY  = 2'd3
    } size_sel_e;

    typedef enum logic {
        KIND_DATA  = 1'b0,
        KIND_FETCH = 1'b1
    } cyc_kind_e;

    // control register layout: [5:4] size, [3:2] direction, [1:0] cycle type
    typedef struct packed {
        size_sel_e size;
        dir_sel_e  dir;
        cyc_sel_e  cyc;
    } chan_ctrl_t;

    typedef struct packed {
        cyc_kind_e  kind;
        logic       write;
        logic [1:0] size;
    } cyc_attr_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_CLR  = 2'd3;

    function automatic logic kind_ok(cyc_sel_e sel, cyc_kind_e kind);
        case (sel)
            CYC_FETCH: return kind == KIND_FETCH;
            CYC_DATA:  return kind == KIND_DATA;
            CYC_ANY:   return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic dir_ok(dir_sel_e sel, logic write);
        case (sel)
            DIR_READ:  return !write;
            DIR_WRITE: return write;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic size_ok(size_sel_e sel, logic [1:0] size);
        if (sel == SZ_ANY) return 1'b1;
        return size == 2'(sel);
    endfunction

endpackage

// File: rtl/bbm_classify.sv
module bbm_classify
    import bbm_pkg::*;
#(
    parameter int          MASTER_W = 2,
    parameter logic [MASTER_W-1:0] CPU_ID = '0
) (
    input  logic                bus_fetch,
    input  logic                bus_write,
    input  logic [1:0]          bus_size,
    input  logic [MASTER_W-1:0] bus_master,
    output cyc_attr_t           attr
);
    // Only the CPU issues instruction fetches (fetch-triggered fills included);
    // every other master, the DMA engine among them, is a data access.
    always_comb begin
        attr.kind  = (bus_fetch && bus_master == CPU_ID) ? KIND_FETCH : KIND_DATA;
        attr.write = bus_write;
        attr.size  = bus_size;
    end
endmodule

// File: rtl/bbm_channel.sv
module bbm_channel
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CH_W   = 1,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  cyc_attr_t         attr,
    output logic              hit,
    output logic              flag
);
    logic [ADDR_W-1:0] cmp_q;
    logic [ADDR_W-1:0] ign_q;
    chan_ctrl_t        ctrl_q;
    logic              sel;

    assign sel = cfg_we && (cfg_ch == CH_W'(CH_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            ign_q  <= '0;
            ctrl_q <= '{size: SZ_ANY, dir: DIR_ANY0, cyc: CYC_NONE};
        end else if (sel) begin
            case (cfg_reg)
                REG_ADDR: cmp_q  <= cfg_wdata;
                REG_MASK: ign_q  <= cfg_wdata;
                REG_CTRL: ctrl_q <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    logic addr_eq;
    assign addr_eq = (((bus_addr ^ cmp_q) & ~ign_q) == '0);

    always_comb begin
        hit = bus_valid && addr_eq
            && kind_ok(ctrl_q.cyc, attr.kind)
            && dir_ok(ctrl_q.dir, attr.write)
            && size_ok(ctrl_q.size, attr.size);
    end

    // set has priority over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (sel && cfg_reg == REG_CLR)
            flag <= 1'b0;
    end
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
    import bbm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_CH   = 2,
    parameter int MASTER_W = 2,
    parameter logic [MASTER_W-1:0] CPU_ID = '0,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CFG_AW  = CH_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_fetch,
    input  logic                bus_write,
    input  logic [1:0]          bus_size,
    input  logic [MASTER_W-1:0] bus_master,
    input  logic                cpu_block,
    output logic [NUM_CH-1:0]   match_flag,
    output logic                break_req
);
    cyc_attr_t         attr;
    logic [NUM_CH-1:0] hits;

    bbm_classify #(.MASTER_W(MASTER_W), .CPU_ID(CPU_ID)) u_cls (
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_master(bus_master),
        .attr      (attr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bbm_channel #(.ADDR_W(ADDR_W), .CH_W(CH_W), .CH_IDX(g)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we),
            .cfg_ch   (cfg_addr[CFG_AW-1:2]),
            .cfg_reg  (cfg_addr[1:0]),
            .cfg_wdata(cfg_wdata),
            .bus_valid(bus_valid),
            .bus_addr (bus_addr),
            .attr     (attr),
            .hit      (hits[g]),
            .flag     (match_flag[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            break_req <= 1'b0;
        else
            break_req <= (|hits) && !cpu_block;
    end
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int NUM_CH = 2,
    parameter int CFG_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              bus_valid,
    input logic              cpu_block,
    input logic [NUM_CH-1:0] match_flag,
    input logic              break_req
);
    p_flag_needs_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (|(match_flag & ~$past(match_flag))) |-> $past(bus_valid));

    p_flag_drop_needs_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (|($past(match_flag) & ~match_flag)) |-> $past(cfg_we && cfg_addr[1:0] == 2'd3));

    p_break_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        break_req |-> $past(!cpu_block && bus_valid));

    p_break_has_flag_r10: assert property (@(posedge clk) disable iff (rst)
        break_req |-> (match_flag != '0));

    p_idle_no_break_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid) |-> !break_req);
endmodule

bind bus_break_matcher bbm_checker #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .bus_valid (bus_valid),
    .cpu_block (cpu_block),
    .match_flag(match_flag),
    .break_req (break_req)
);

// File: tb/sim_bus_break_matcher.sv
module sim_bus_break_matcher;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic        bus_fetch;
    logic        bus_write;
    logic [1:0]  bus_size;
    logic [1:0]  bus_master;
    logic        cpu_block;
    logic [1:0]  match_flag;
    logic        break_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_break_matcher u0 (.*);

    typedef struct {
        logic [1:0] flags;
        logic       brk;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // monitor: result of the cycle sampled at an edge is checked just after it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (match_flag !== e.flags || break_req !== e.brk) begin
                n_fail++;
                $display("FAIL %s: flags=%b brk=%b expected flags=%b brk=%b",
                         e.tag, match_flag, break_req, e.flags, e.brk);
            end
        end
    end

    task automatic step(input logic we, input logic [2:0] ca, input logic [31:0] cd,
                        input logic bv, input logic [31:0] a, input logic f,
                        input logic w, input logic [1:0] sz, input logic [1:0] m,
                        input logic blk, input logic [1:0] ef, input logic eb,
                        input string tag);
        @(negedge clk);
        cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
        bus_valid = bv; bus_addr = a; bus_fetch = f; bus_write = w;
        bus_size = sz; bus_master = m; cpu_block = blk;
        exp_q.push_back('{ef, eb, tag});
    endtask

    task automatic cfg(input logic [2:0] ca, input logic [31:0] cd,
                       input logic [1:0] ef, input string tag);
        step(1'b1, ca, cd, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, ef, 1'b0, tag);
    endtask

    task automatic bus(input logic [31:0] a, input logic f, input logic w,
                       input logic [1:0] sz, input logic [1:0] m, input logic blk,
                       input logic [1:0] ef, input logic eb, input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b1, a, f, w, sz, m, blk, ef, eb, tag);
    endtask

    task automatic idle(input logic [1:0] ef, input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, ef, 1'b0, tag);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; bus_valid = 0;
        bus_addr = 0; bus_fetch = 0; bus_write = 0; bus_size = 0;
        bus_master = 0; cpu_block = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state; a matching-address cycle on a default channel sets nothing
        idle(2'b00, "R1 reset flags");
        bus(32'h0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R1 channels disabled after reset");

        // channel 0: address 0x1000_0040, low nibble ignored, any cycle
        cfg(3'd0, 32'h1000_0040, 2'b00, "cfg");
        cfg(3'd1, 32'h0000_000F, 2'b00, "cfg");
        cfg(3'd2, 32'h33, 2'b00, "cfg");
        cfg(3'd4, 32'h2000_0000, 2'b00, "cfg");

        // R2 / R8
        bus(32'h1000_0048, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b01, 1'b1, "R2 masked address match");
        idle(2'b01, "R8 break is one-cycle pulse");
        bus(32'h1000_0058, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b01, 1'b0, "R2 unmasked bit differs");
        cfg(3'd3, 32'h0, 2'b00, "R7 clear channel 0");
        bus(32'h1000_0050, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R2 unmasked mismatch no flag");
        bus(32'h1000_004F, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'b01, 1'b1, "R2 mask boundary match");
        cfg(3'd3, 32'h0, 2'b00, "R7 clear channel 0");

        // R3 / R4 on channel 1
        bus(32'h2000_0000, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R3 none select disabled");
        cfg(3'd6, 32'h31, 2'b00, "cfg fetch only");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R3 fetch-only rejects data");
        bus(32'h2000_0000, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 2'b00, 1'b0, "R4 DMA fetch bit is data");
        bus(32'h2000_0000, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10, 1'b1, "R4 CPU fetch matches");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");
        cfg(3'd6, 32'h32, 2'b00, "cfg data only");
        bus(32'h2000_0000, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R3 data-only rejects fetch");
        bus(32'h2000_0000, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 2'b10, 1'b1, "R4 DMA counts as data");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");

        // R5 direction
        cfg(3'd6, 32'h37, 2'b00, "cfg read only");
        bus(32'h2000_0000, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R5 read-only rejects write");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10, 1'b1, "R5 read-only accepts read");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");
        cfg(3'd6, 32'h3B, 2'b00, "cfg write only");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R5 write-only rejects read");
        bus(32'h2000_0000, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 2'b10, 1'b1, "R5 write-only accepts write");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");

        // R6 size
        cfg(3'd6, 32'h13, 2'b00, "cfg word only");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'b00, 1'b0, "R6 byte rejected");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 2'b00, 1'b0, "R6 long rejected");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 2'b10, 1'b1, "R6 word accepted");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");

        // R9 block bit, R7 set-over-clear and stickiness
        cfg(3'd6, 32'h33, 2'b00, "cfg any");
        bus(32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 2'b10, 1'b0, "R9 blocked: flag only");
        step(1'b1, 3'd7, 32'h0, 1'b1, 32'h2000_0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0,
             2'b10, 1'b1, "R7 match wins over clear");
        idle(2'b10, "R7 flag sticky");
        idle(2'b10, "R7 flag sticky");
        cfg(3'd7, 32'h0, 2'b00, "R7 clear channel 1");

        // R10 / R11: one cycle from master 3 hits both channels
        cfg(3'd5, 32'hF000_00FF, 2'b00, "cfg ch1 mask");
        bus(32'h1000_0040, 1'b0, 1'b0, 2'd2, 2'd3, 1'b0, 2'b11, 1'b1, "R11 other master, R10 both");
        cfg(3'd3, 32'h0, 2'b10, "R10 clear ch0 keeps ch1");
        bus(32'h1000_0041, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 2'b11, 1'b0, "R9 R11 blocked sets flag");
        idle(2'b11, "R8 no break when idle");
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule